// File: doc/BRIEF.md
# Glitch-Free Encoded Select Crossing

This block carries a small binary select code from one clock domain into a second, unrelated clock domain. In the receiving domain it decodes the code into a set of active-low select lines, one per code value. A multi-bit code sampled by an unrelated clock can be caught half-changed. To keep a half-changed code away from the outputs, the sender frames the code with a separate active-low qualifier. The qualifier goes active only after the code has been stable for one sender cycle, and it goes inactive one sender cycle before the code may change again.

On the sending side, a requester raises a request together with the new code. While `s_busy` is low, the sequencer takes the request, drives the code, opens the qualifier for a programmable number of sender cycles, closes it, and holds the code for one more cycle before it goes idle again. In the receiving domain, each code bit and the qualifier pass through their own two-flop synchronizers. The registered decoder drives a select line low only while the synchronized qualifier is active. The number of qualifier cycles must be set so that the qualifier stays active for longer than the slowest receiving clock period.

Top module: `enc_sel_cdc`

## Requirements
- R1: A request is accepted on a rising `s_clk` edge where `s_req` is 1 and `s_busy` is 0. `s_busy` then reads 1 for exactly HOLD_CYC+2 consecutive sender cycles, starting with the cycle after that edge.
- R2: The internal qualifier goes low only on an edge where the driven code keeps the value it already held the cycle before.
- R3: The driven code does not change while the qualifier is low, nor on the first sender edge after it returns high.
- R4: For each accepted request, the qualifier stays low for exactly HOLD_CYC sender cycles.
- R5: Whenever the synchronized qualifier was inactive on the previous receiving edge, all select outputs read 1. After a transfer ends, the outputs settle back to all ones.
- R6: At most one select output is 0 at any receiving edge. A select line other than the one for the requested code never goes low, whatever the clock ratio and phase.
- R7: Code value n drives bit n of `r_sel_n` low. For each transfer, that line goes low at least once in the receiving domain.
- R8: A request raised while `s_busy` is 1 is ignored. It neither changes the code in flight nor lengthens or repeats the busy window.
- R9: While `s_rst_n` is low, `s_busy` is 0 and the qualifier is inactive. While `r_rst_n` is low, `r_sel_n` is all ones, including when both resets strike in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sending-domain clock |
| s_rst_n | input | 1 | Sending-domain asynchronous reset, active low |
| s_req | input | 1 | Request to send a new code |
| s_code | input | CODE_W | Code to send, sampled when the request is accepted |
| s_busy | output | 1 | High from acceptance until the code is released |
| r_clk | input | 1 | Receiving-domain clock |
| r_rst_n | input | 1 | Receiving-domain asynchronous reset, active low |
| r_sel_n | output | 2**CODE_W | Decoded select lines, active low |

## Verification
Four properties are checked at every clock edge of their own domain: that the qualifier is framed inside the code's stable window and held for exactly HOLD_CYC cycles; that no select goes low while the synchronized qualifier is off; that never more than one select line is low; and the reset levels of both sides. Only the bench scenarios can show the rest. They cover the correct line being reached at each of many receiving-clock periods and phases, and the absence of any stray low line over a whole transfer. They also show that a request made mid-transfer is dropped, and that the block recovers after a reset that strikes while the qualifier is open.

// File: rtl/enc_sel_pkg.sv
package enc_sel_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_HOLD  = 2'd2,
    TX_TAIL  = 2'd3
  } tx_state_e;

  // total sender cycles a transfer keeps the sequencer occupied
  function automatic int busy_span(input int hold_cyc);
    return hold_cyc + 2;
  endfunction

endpackage

// File: rtl/enc_sel_tx.sv
module enc_sel_tx
  import enc_sel_pkg::*;
#(
  parameter int CODE_W   = 2,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] code_in,
  output logic              busy,
  output logic [CODE_W-1:0] code_out,
  output logic              qual_n
);

  localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code_q;
  logic              qual_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      cnt      <= '0;
      code_q   <= '0;
      qual_n_q <= 1'b1;
    end else begin
      unique case (state)
        TX_IDLE: begin
          if (req) begin
            code_q <= code_in;
            state  <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          qual_n_q <= 1'b0;
          cnt      <= CNT_W'(HOLD_CYC - 1);
          state    <= TX_HOLD;
        end
        TX_HOLD: begin
          if (cnt == '0) begin
            qual_n_q <= 1'b1;
            state    <= TX_TAIL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        TX_TAIL: state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy     = (state != TX_IDLE);
  assign code_out = code_q;
  assign qual_n   = qual_n_q;

endmodule

// File: rtl/enc_sel_sync2.sv
module enc_sel_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d[b];
        sync_q <= meta_q;
      end
    end
    assign q[b] = sync_q;
  end

endmodule

// File: rtl/enc_sel_rx.sv
module enc_sel_rx #(
  parameter int CODE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code,
  input  logic                 qual_n,
  output logic [2**CODE_W-1:0] sel_n
);

  localparam int SEL_N = 2**CODE_W;

  function automatic logic [SEL_N-1:0] decode_n(input logic [CODE_W-1:0] c);
    logic [SEL_N-1:0] v;
    v = '1;
    v[c] = 1'b0;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_n <= '1;
    else if (qual_n) sel_n <= '1;
    else sel_n <= decode_n(code);
  end

endmodule

// File: rtl/enc_sel_cdc.sv
module enc_sel_cdc #(
  parameter int CODE_W   = 2,
  parameter int HOLD_CYC = 4
) (
  input  logic                 s_clk,
  input  logic                 s_rst_n,
  input  logic                 s_req,
  input  logic [CODE_W-1:0]    s_code,
  output logic                 s_busy,
  input  logic                 r_clk,
  input  logic                 r_rst_n,
  output logic [2**CODE_W-1:0] r_sel_n
);

  logic [CODE_W-1:0] s_code_w;
  logic              s_en_n_w;
  logic [CODE_W-1:0] r_code_sync;
  logic              r_en_sync_n;

  enc_sel_tx #(.CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC)) u_tx (
    .clk(s_clk), .rst_n(s_rst_n), .req(s_req), .code_in(s_code),
    .busy(s_busy), .code_out(s_code_w), .qual_n(s_en_n_w)
  );

  enc_sel_sync2 #(.W(CODE_W), .RST_VAL('0)) u_sync_code (
    .clk(r_clk), .rst_n(r_rst_n), .d(s_code_w), .q(r_code_sync)
  );

  enc_sel_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync_en (
    .clk(r_clk), .rst_n(r_rst_n), .d(s_en_n_w), .q(r_en_sync_n)
  );

  enc_sel_rx #(.CODE_W(CODE_W)) u_rx (
    .clk(r_clk), .rst_n(r_rst_n), .code(r_code_sync),
    .qual_n(r_en_sync_n), .sel_n(r_sel_n)
  );

endmodule

// File: rtl/enc_sel_cdc_chk.sv
module enc_sel_cdc_chk #(
  parameter int CODE_W   = 2,
  parameter int HOLD_CYC = 4
) (
  input logic                 s_clk,
  input logic                 s_rst_n,
  input logic                 s_req,
  input logic                 s_busy,
  input logic [CODE_W-1:0]    s_code_w,
  input logic                 s_en_n_w,
  input logic                 r_clk,
  input logic                 r_rst_n,
  input logic                 r_en_sync_n,
  input logic [2**CODE_W-1:0] r_sel_n
);

  localparam int LC_W = $clog2(HOLD_CYC + 2) + 1;
  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) low_cnt <= '0;
    else if (!s_en_n_w) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_BUSY_FROM_REQ: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(s_busy) |-> $past(s_req)); // R1

  AST_EN_AFTER_CODE: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $fell(s_en_n_w) |-> $stable(s_code_w)); // R2

  AST_CODE_HELD: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (!$past(s_en_n_w) || !$past(s_en_n_w, 2)) |-> $stable(s_code_w)); // R3

  AST_EN_WIDTH: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(s_en_n_w) |-> (low_cnt == LC_W'(HOLD_CYC))); // R4

  AST_GATED_IDLE: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    $past(r_en_sync_n) |-> (r_sel_n == '1)); // R5

  AST_ONE_LOW: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    $countones(~r_sel_n) <= 1); // R6

  AST_TX_RESET: assert property (@(posedge s_clk)
    !s_rst_n |-> (s_en_n_w && !s_busy)); // R9

  AST_RX_RESET: assert property (@(posedge r_clk)
    !r_rst_n |-> (r_sel_n == '1)); // R9

endmodule

bind enc_sel_cdc enc_sel_cdc_chk #(.CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC)) u_chk (
  .s_clk(s_clk), .s_rst_n(s_rst_n), .s_req(s_req), .s_busy(s_busy),
  .s_code_w(s_code_w), .s_en_n_w(s_en_n_w), .r_clk(r_clk), .r_rst_n(r_rst_n),
  .r_en_sync_n(r_en_sync_n), .r_sel_n(r_sel_n)
);

// File: tb/enc_sel_cdc_bench.sv
`timescale 1ns/1ps
module enc_sel_cdc_bench;

  localparam int CODE_W   = 2;
  localparam int HOLD_CYC = 4;
  localparam int SEL_N    = 2**CODE_W;
  localparam int NVEC     = 10;
  // each entry: {code[7:6], receiving half period in ns [5:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    {2'd0, 6'd5},  {2'd1, 6'd3},  {2'd2, 6'd15}, {2'd3, 6'd7},
    {2'd1, 6'd11}, {2'd2, 6'd2},  {2'd3, 6'd13}, {2'd0, 6'd9},
    {2'd2, 6'd6},  {2'd1, 6'd14}
  };

  logic              s_clk = 1'b0;
  logic              r_clk = 1'b0;
  logic              s_rst_n = 1'b1;
  logic              r_rst_n = 1'b1;
  logic              s_req = 1'b0;
  logic [CODE_W-1:0] s_code = '0;
  logic              s_busy;
  logic [SEL_N-1:0]  r_sel_n;

  int n_chk  = 0;
  int n_fail = 0;
  int r_half = 5;
  bit done   = 1'b0;

  // receive-side monitor state
  bit                mon_on = 1'b0;
  logic [CODE_W-1:0] exp_code = '0;
  bit                seen = 1'b0;
  bit                stray = 1'b0;

  enc_sel_cdc #(.CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC)) u_enc_sel_cdc (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_req(s_req), .s_code(s_code),
    .s_busy(s_busy), .r_clk(r_clk), .r_rst_n(r_rst_n), .r_sel_n(r_sel_n)
  );

  always #5 s_clk = ~s_clk;
  always begin
    #(r_half);
    r_clk = ~r_clk;
  end

  always @(negedge r_clk) begin
    if (mon_on) begin
      for (int i = 0; i < SEL_N; i++) begin
        if (!r_sel_n[i]) begin
          if (i == int'(exp_code)) seen = 1'b1;
          else stray = 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int want_busy();
    return HOLD_CYC + 2;
  endfunction

  // one transfer; optionally pokes a second request while busy
  task automatic xfer(input logic [CODE_W-1:0] code, input bit poke,
                      input logic [CODE_W-1:0] poke_code);
    int len;
    exp_code = code;
    seen  = 1'b0;
    stray = 1'b0;
    mon_on = 1'b1;
    @(negedge s_clk);
    s_req  = 1'b1;
    s_code = code;
    @(negedge s_clk);
    s_req = 1'b0;
    len = 0;
    while (s_busy) begin
      len++;
      if (poke && len == 2) begin
        s_req  = 1'b1;
        s_code = poke_code;
      end else begin
        s_req = 1'b0;
      end
      @(negedge s_clk);
    end
    s_req = 1'b0;
    check(len == want_busy(), "R1 busy window length", len, want_busy());
    if (poke) begin
      repeat (3) @(negedge s_clk);
      check(!s_busy, "R8 request during busy not started", int'(s_busy), 0);
    end
    repeat (8) @(negedge r_clk);
    check(seen, "R7 expected select line went low", int'(seen), 1);
    check(!stray, "R6 no stray select line low", int'(stray), 0);
    check(r_sel_n == '1, "R5 selects idle after transfer", int'(r_sel_n), SEL_N*0 + (2**SEL_N - 1));
    mon_on = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    s_rst_n = 1'b0;
    r_rst_n = 1'b0;
    #2;
    // R9: reset state
    check(s_busy == 1'b0, "R9 busy in reset", int'(s_busy), 0);
    check(r_sel_n == '1, "R9 selects in reset", int'(r_sel_n), 2**SEL_N - 1);
    repeat (3) @(negedge s_clk);
    s_rst_n = 1'b1;
    r_rst_n = 1'b1;
    repeat (2) @(negedge s_clk);

    // table walk: varying clock ratio and phase
    for (int v = 0; v < NVEC; v++) begin
      r_half = int'(VEC[v][5:0]);
      repeat ($urandom_range(0, 3)) @(negedge s_clk);
      #($urandom_range(0, 4));
      xfer(VEC[v][7:6], 1'b0, '0);
    end

    // R8: intruding request with another code is dropped
    r_half = 4;
    xfer(2'd1, 1'b1, 2'd2);
    r_half = 14;
    xfer(2'd3, 1'b1, 2'd0);

    // R9: both resets in the middle of an open qualifier
    r_half = 3;
    exp_code = 2'd2;
    @(negedge s_clk);
    s_req  = 1'b1;
    s_code = 2'd2;
    @(negedge s_clk);
    s_req = 1'b0;
    repeat (4) @(negedge s_clk);
    check(r_sel_n == 4'b1011, "R7 line 2 low before reset", int'(r_sel_n), 11);
    s_rst_n = 1'b0;
    r_rst_n = 1'b0;
    #1;
    check(r_sel_n == '1, "R9 selects forced high mid transfer", int'(r_sel_n), 2**SEL_N - 1);
    check(s_busy == 1'b0, "R9 busy cleared mid transfer", int'(s_busy), 0);
    repeat (3) @(negedge s_clk);
    s_rst_n = 1'b1;
    r_rst_n = 1'b1;
    repeat (2) @(negedge s_clk);
    xfer(2'd0, 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule